// File: doc/BRIEF.md
# Two-Wire Bus Condition Front End

This block sits between the raw clock and data pins of a two-wire serial bus and the byte-level slave controller. It samples both lines with the fast system clock through a two-flop synchronizer, then rejects short spikes with a per-line digital filter. The filtered levels feed an edge and condition detector. The detector issues one-cycle strobes for START, STOP, repeated START, clock rising edge and clock falling edge. It also keeps a bus-busy flag that is set by START and cleared by STOP.

For the transmit direction, the slave controller states on one input whether it wants the data line pulled low. The block passes that request to the pin driver only while the filtered clock is low, and only after a programmable hold time has passed since the last clock falling edge. A data change driven by the slave therefore never lands in the ambiguous part of the falling edge and cannot be read as a START or STOP.

Top module: `i2c_bus_frontend`

## Requirements
- R1: After reset, all strobes are 0, `busy_o` is 0, `sda_oe_o` is 0, and `scl_o` and `sda_o` are 1.
- R2: A data line falling from 1 to 0 while the filtered clock stays 1 gives exactly one `start_o` pulse, and `busy_o` is 1 from the next cycle onward.
- R3: A data line rising from 0 to 1 while the filtered clock stays 1 gives exactly one `stop_o` pulse, and `busy_o` is 0 from the next cycle onward.
- R4: A START while `busy_o` is 1 pulses `rstart_o` in the same cycle as `start_o`, and `busy_o` stays 1. A START from idle does not pulse `rstart_o`.
- R5: A data change while the clock is low produces neither START nor STOP. Each clock pulse produces exactly one `scl_rise_o` and one `scl_fall_o`.
- R6: A raw pulse shorter than FILT_CYC system cycles, on either line, changes neither `scl_o` nor `sda_o` and produces no strobe. A level held for FILT_CYC cycles or longer is passed on.
- R7: `sda_oe_o` (1 = pull the data line low) takes the value of `sda_drive_low_i` only while the filtered clock is low, and no earlier than HOLD_CYC cycles after `scl_fall_o`. It does not change while the filtered clock is high.
- R8: Every strobe is one system clock wide, and `start_o` and `stop_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_raw_i | input | 1 | Raw bus clock pin level |
| sda_raw_i | input | 1 | Raw bus data pin level |
| sda_drive_low_i | input | 1 | Slave request to pull the data line low |
| sda_oe_o | output | 1 | Hold-timed data line pull-down enable |
| scl_o | output | 1 | Filtered clock level |
| sda_o | output | 1 | Filtered data level |
| start_o | output | 1 | START strobe |
| stop_o | output | 1 | STOP strobe |
| rstart_o | output | 1 | Repeated START strobe |
| scl_rise_o | output | 1 | Clock rising edge strobe |
| scl_fall_o | output | 1 | Clock falling edge strobe |
| busy_o | output | 1 | Bus busy between START and STOP |

## Verification
If a filter counter is wrong, the fault appears at the ports about FILT_CYC cycles after the raw input changes. A glitch then gets through as a stray strobe, or a valid level never arrives and the expected edge count comes up short. A busy flag in the wrong state is visible in the next cycle, either as a missing or extra `rstart_o` or as `busy_o` disagreeing with the last START or STOP. A fault in the hold counter shows up within about HOLD_CYC cycles of a clock fall, as `sda_oe_o` moving too early or moving while the clock is high.

// File: rtl/i2c_fe_pkg.sv
package i2c_fe_pkg;
  localparam int unsigned LINE_SCL = 0;
  localparam int unsigned LINE_SDA = 1;
  localparam int unsigned N_LINES  = 2;

  typedef struct packed {
    logic start;
    logic stop;
    logic rstart;
    logic rise;
    logic fall;
  } bus_ev_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYC    = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic level_o
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYC - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   lvl_q;
  logic                   s_in;

  assign s_in = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  // level moves only after FILT_CYC consecutive disagreeing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else if (s_in == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q <= '0;
      lvl_q <= s_in;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign level_o = lvl_q;

  // R6
  level_needs_disagree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != $past(lvl_q)) |-> ($past(s_in) != $past(lvl_q)));
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
  import i2c_fe_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev_o,
  output logic    busy_o
);
  logic scl_q, sda_q, busy_q;
  bus_ev_t ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // conditions need SCL high on both samples so a simultaneous edge is not a condition
  always_comb begin
    ev.start  = scl_i & scl_q & sda_q & ~sda_i;
    ev.stop   = scl_i & scl_q & ~sda_q & sda_i;
    ev.rstart = ev.start & busy_q;
    ev.rise   = scl_i & ~scl_q;
    ev.fall   = ~scl_i & scl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       busy_q <= 1'b0;
    else if (ev.start) busy_q <= 1'b1;
    else if (ev.stop)  busy_q <= 1'b0;
  end

  assign ev_o   = ev;
  assign busy_o = busy_q;

  // R2
  busy_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev.start |=> busy_q);
  // R3
  idle_after_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev.stop |=> !busy_q);
  // R8
  start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev.start |=> !ev.start);
  // R8
  no_start_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ev.start && ev.stop));
  // R5
  cond_scl_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev.start || ev.stop) |-> (scl_i && $past(scl_i)));
endmodule

// File: rtl/i2c_sda_hold.sv
module i2c_sda_hold #(
  parameter int unsigned HOLD_CYC = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic scl_fall_i,
  input  logic drive_low_i,
  output logic oe_o
);
  localparam int unsigned HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] HOLD_MAX = HW'(HOLD_CYC);

  logic [HW-1:0] cnt_q;
  logic          oe_q;
  logic          open_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (scl_fall_i)                   cnt_q <= '0;
    else if (!scl_i && cnt_q != HOLD_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign open_w = !scl_i && !scl_fall_i && (cnt_q == HOLD_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     oe_q <= 1'b0;
    else if (open_w) oe_q <= drive_low_i;
  end

  assign oe_o = oe_q;

  // R7
  oe_frozen_scl_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q != $past(oe_q)) |-> !$past(scl_i));
  // R7
  oe_not_at_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_fall_i |=> $stable(oe_q));
endmodule

// File: rtl/i2c_bus_frontend.sv
module i2c_bus_frontend
  import i2c_fe_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYC    = 10,
  parameter int unsigned HOLD_CYC    = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_raw_i,
  input  logic sda_raw_i,
  input  logic sda_drive_low_i,
  output logic sda_oe_o,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rstart_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic busy_o
);
  logic [N_LINES-1:0] raw, lvl;
  bus_ev_t ev;

  assign raw[LINE_SCL] = scl_raw_i;
  assign raw[LINE_SDA] = sda_raw_i;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_CYC   (FILT_CYC)
    ) i_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw[g]),
      .level_o(lvl[g])
    );
  end

  i2c_cond_detect i_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (lvl[LINE_SCL]),
    .sda_i (lvl[LINE_SDA]),
    .ev_o  (ev),
    .busy_o(busy_o)
  );

  i2c_sda_hold #(.HOLD_CYC(HOLD_CYC)) i_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (lvl[LINE_SCL]),
    .scl_fall_i (ev.fall),
    .drive_low_i(sda_drive_low_i),
    .oe_o       (sda_oe_o)
  );

  assign scl_o      = lvl[LINE_SCL];
  assign sda_o      = lvl[LINE_SDA];
  assign start_o    = ev.start;
  assign stop_o     = ev.stop;
  assign rstart_o   = ev.rstart;
  assign scl_rise_o = ev.rise;
  assign scl_fall_o = ev.fall;

  // R4
  rstart_keeps_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rstart_o |-> (busy_o && start_o));
endmodule

// File: tb/test_i2c_bus_frontend.sv
module test_i2c_bus_frontend;
  localparam int unsigned FILT = 10;
  localparam int unsigned HOLD = 30;
  localparam int unsigned STEP = 24;
  localparam int NV = 17;
  // {scl, sda, n_start, n_stop, n_rstart, n_rise, n_fall, busy_after}
  localparam logic [7:0] VEC [NV] = '{
    8'b11_00000_0, 8'b10_10000_1, 8'b00_00001_1, 8'b01_00000_1,
    8'b11_00010_1, 8'b01_00001_1, 8'b00_00000_1, 8'b10_00010_1,
    8'b11_01000_0, 8'b10_10000_1, 8'b00_00001_1, 8'b01_00000_1,
    8'b11_00010_1, 8'b10_10100_1, 8'b00_00001_1, 8'b10_00010_1,
    8'b11_01000_0
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_raw = 1'b1, sda_raw = 1'b1, drv_low = 1'b0;
  logic sda_oe, scl_f, sda_f, st, sp, rst_s, rise, fall, busy;
  int checks = 0, fails = 0;
  int n_st = 0, n_sp = 0, n_rs = 0, n_ri = 0, n_fa = 0, n_sda_lo = 0;
  int wide = 0;
  logic st_d = 1'b0, sp_d = 1'b0, ri_d = 1'b0, fa_d = 1'b0;

  always #5 clk = ~clk;

  i2c_bus_frontend #(.FILT_CYC(FILT), .HOLD_CYC(HOLD)) i_i2c_bus_frontend (
    .clk_i(clk), .rst_ni(rst_n), .scl_raw_i(scl_raw), .sda_raw_i(sda_raw),
    .sda_drive_low_i(drv_low), .sda_oe_o(sda_oe), .scl_o(scl_f), .sda_o(sda_f),
    .start_o(st), .stop_o(sp), .rstart_o(rst_s), .scl_rise_o(rise),
    .scl_fall_o(fall), .busy_o(busy)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      n_st <= n_st + int'(st);
      n_sp <= n_sp + int'(sp);
      n_rs <= n_rs + int'(rst_s);
      n_ri <= n_ri + int'(rise);
      n_fa <= n_fa + int'(fall);
      n_sda_lo <= n_sda_lo + int'(!sda_f);
      if ((st && st_d) || (sp && sp_d) || (rise && ri_d) || (fall && fa_d) || (st && sp))
        wide <= wide + 1;
    end
    st_d <= st; sp_d <= sp; ri_d <= rise; fa_d <= fall;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int b_st, b_sp, b_rs, b_ri, b_fa, b_lo, n;
    wait_cyc(3);
    // R1 reset state
    check("R1 strobes", int'({st, sp, rst_s, rise, fall}), 0);
    check("R1 busy/oe", int'({busy, sda_oe}), 0);
    check("R1 levels", int'({scl_f, sda_f}), 3);
    rst_n = 1'b1;
    wait_cyc(2);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      b_st = n_st; b_sp = n_sp; b_rs = n_rs; b_ri = n_ri; b_fa = n_fa;
      scl_raw = VEC[i][7];
      sda_raw = VEC[i][6];
      wait_cyc(STEP);
      check($sformatf("R2/R3/R4/R5 step %0d", i),
            int'({1'(n_st - b_st), 1'(n_sp - b_sp), 1'(n_rs - b_rs),
                  1'(n_ri - b_ri), 1'(n_fa - b_fa), busy}),
            int'(VEC[i][5:0]));
    end

    // R6 short glitches on idle bus
    b_st = n_st; b_fa = n_fa; b_lo = n_sda_lo;
    sda_raw = 1'b0; wait_cyc(FILT - 2); sda_raw = 1'b1; wait_cyc(STEP);
    scl_raw = 1'b0; wait_cyc(FILT - 2); scl_raw = 1'b1; wait_cyc(STEP);
    check("R6 glitch strobes", (n_st - b_st) + (n_fa - b_fa), 0);
    check("R6 sda level unchanged", n_sda_lo - b_lo, 0);
    // R6 long pulse accepted
    b_st = n_st; b_sp = n_sp;
    sda_raw = 1'b0; wait_cyc(FILT + 3); sda_raw = 1'b1; wait_cyc(STEP);
    check("R6 long pulse start", n_st - b_st, 1);
    check("R6 long pulse stop", n_sp - b_sp, 1);

    // R7 request while clock high is held off
    drv_low = 1'b1; wait_cyc(STEP);
    check("R7 oe idle high clock", int'(sda_oe), 0);
    sda_raw = 1'b0; wait_cyc(STEP);
    scl_raw = 1'b0;
    n = 0;
    while (!fall && n < 100) begin @(negedge clk); n++; end
    n = 0;
    while (!sda_oe && n < 200) begin @(negedge clk); n++; end
    check("R7 hold lower bound", int'(n >= HOLD), 1);
    check("R7 hold upper bound", int'(n <= HOLD + 3), 1);
    scl_raw = 1'b1;
    n = 0;
    while (!scl_f && n < 100) begin @(negedge clk); n++; end
    drv_low = 1'b0;
    wait_cyc(STEP);
    check("R7 oe frozen clock high", int'(sda_oe), 1);
    scl_raw = 1'b0;
    n = 0;
    while (!fall && n < 100) begin @(negedge clk); n++; end
    wait_cyc(HOLD - 2);
    check("R7 oe held inside window", int'(sda_oe), 1);
    wait_cyc(6);
    check("R7 oe released after window", int'(sda_oe), 0);
    scl_raw = 1'b1; wait_cyc(STEP);
    sda_raw = 1'b1; wait_cyc(STEP);
    check("R3 final stop idle", int'(busy), 0);

    // R8 strobe width and exclusivity
    check("R8 strobe width", wide, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule